// File: doc/BRIEF.md
# Bridge Memory Window Address Decoder

This block sits beside the host side of a bridge that forwards memory requests to a downstream port. It keeps two programmable address windows: one for control-style, non-prefetchable memory and one for prefetchable memory. Each window is defined by a base register and a limit register. For every host request it reports whether the 32-bit address falls inside either window, so the surrounding logic can decide to route the request downstream.

Both boundaries have a granularity of 1 MB. Only the twelve most significant address bits of each boundary are stored. A base always starts a 1 MB block. A limit always ends one, because its low twenty address bits count as all ones. Configuration software reads and writes the four registers through a 16-bit port with one enable per byte. Software must keep the windows from overlapping; the block does not check for overlap.

Top module: `mem_window_decoder`

## Requirements
- R1: After a synchronous reset, every register reads back as 0x0000, and `hit_valid`, `hit_np` and `hit_pf` are low.
- R2: In each register, bits 15:4 are writable and hold address bits 31:20 of the boundary. Bits 3:0 always read as zero, and data written to them has no effect.
- R3: `cfg_be[1]` enables the write of register bits 15:8 and `cfg_be[0]` enables the write of bits 7:4. A byte whose enable is low keeps its old value.
- R4: `cfg_sel` selects the register: 0 is the non-prefetchable base, 1 the non-prefetchable limit, 2 the prefetchable base and 3 the prefetchable limit.
- R5: `cfg_rdata` takes the value of the selected register one clock after `cfg_rd_en` is sampled high. It holds its value in every other cycle.
- R6: A window claims an address when base·2^20 ≤ address ≤ limit·2^20 + 0xFFFFF. Here base and limit are the 12-bit fields.
- R7: The boundaries are inclusive. The address exactly at the base is claimed, and so is the last byte of the limit's 1 MB block. The address one below the base is not claimed, and neither is the first address after the limit block.
- R8: A window whose base field is greater than its limit field claims nothing. A window whose base field equals its limit field claims exactly one 1 MB block.
- R9: The two windows decode independently. `hit_np` reflects only the non-prefetchable pair and `hit_pf` only the prefetchable pair.
- R10: `hit_valid` is high exactly one clock after `req_valid` is sampled high. `hit_np` and `hit_pf` are low whenever `hit_valid` is low.
- R11: A request sampled on the clock after a write was accepted is decoded with the new register value.
- R12: With the reset values (base 0, limit 0), each window covers only the first 1 MB. Addresses at or above 0x00100000 are claimed by neither window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_sel | input | 2 | Register select |
| cfg_be | input | 2 | Byte enables for the write data |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Registered read data |
| req_valid | input | 1 | Host request address strobe |
| req_addr | input | 32 | Host request address |
| hit_valid | output | 1 | Decode result valid |
| hit_np | output | 1 | Address claimed by the non-prefetchable window |
| hit_pf | output | 1 | Address claimed by the prefetchable window |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 1 MB granularity, a 16-bit register and two windows. With these values the 12-bit field covers the whole 4 GB space. The bench can therefore reach every kind of boundary: the first address outside a window, the last byte of a limit block, the very top address 0xFFFFFFFF, a window of a single block and an inverted window. It also reaches decodes issued on the cycle right after a write, and byte-enable writes that leave the other byte of a register untouched.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  // Default geometry of the decoder.
  localparam int unsigned ADDR_W_DEF  = 32;
  localparam int unsigned GRAN_W_DEF  = 20;  // implicit low bits of a boundary
  localparam int unsigned REG_W_DEF   = 16;
  localparam int unsigned NUM_WIN_DEF = 2;

  // Window indices; cfg_sel = {window, is_limit}.
  localparam int unsigned WIN_NP = 0;
  localparam int unsigned WIN_PF = 1;

  typedef enum logic {
    BOUND_BASE  = 1'b0,
    BOUND_LIMIT = 1'b1
  } bound_e;
endpackage

// File: rtl/mwd_regfile.sv
module mwd_regfile #(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned REG_W   = 16,
  parameter int unsigned FIELD_W = 12,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned BE_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [SEL_W-1:0]           sel,
  input  logic [BE_W-1:0]            be,
  input  logic [REG_W-1:0]           wdata,
  output logic [REG_W-1:0]           rdata,
  output logic [NUM_WIN*FIELD_W-1:0] base_flat,
  output logic [NUM_WIN*FIELD_W-1:0] limit_flat
);
  import mwd_pkg::*;

  localparam int unsigned LOW_W = REG_W - FIELD_W;

  logic [FIELD_W-1:0] base_q  [NUM_WIN];
  logic [FIELD_W-1:0] limit_q [NUM_WIN];

  logic [SEL_W-2:0] win_sel;
  bound_e           bnd_sel;

  assign win_sel = sel[SEL_W-1:1];
  assign bnd_sel = bound_e'(sel[0]);

  // Merge a write into a stored field. Each field bit sits at register
  // bit FIELD_BIT+LOW_W, and the byte enable of that byte gates it.
  function automatic logic [FIELD_W-1:0] merge_field(
    input logic [FIELD_W-1:0] old_f,
    input logic [REG_W-1:0]   wd,
    input logic [BE_W-1:0]    b
  );
    logic [FIELD_W-1:0] res;
    for (int i = 0; i < int'(FIELD_W); i++) begin
      res[i] = b[(i + int'(LOW_W)) / 8] ? wd[i + int'(LOW_W)] : old_f[i];
    end
    return res;
  endfunction

  // One base/limit storage pair per window.
  for (genvar w = 0; w < int'(NUM_WIN); w++) begin : g_win
    logic hit_sel;
    assign hit_sel = wr_en && (win_sel == w[SEL_W-2:0]);

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[w]  <= '0;
        limit_q[w] <= '0;
      end else if (hit_sel) begin
        if (bnd_sel == BOUND_BASE) base_q[w]  <= merge_field(base_q[w], wdata, be);
        else                       limit_q[w] <= merge_field(limit_q[w], wdata, be);
      end
    end

    assign base_flat[w*FIELD_W +: FIELD_W]  = base_q[w];
    assign limit_flat[w*FIELD_W +: FIELD_W] = limit_q[w];
  end

  // Registered read-back; the read-only low bits return zero.
  logic [FIELD_W-1:0] rd_field;
  always_comb begin
    rd_field = '0;
    for (int w = 0; w < int'(NUM_WIN); w++) begin
      if (win_sel == w[SEL_W-2:0]) begin
        rd_field = (bnd_sel == BOUND_BASE) ? base_q[w] : limit_q[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= {rd_field, {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/mwd_window_match.sv
module mwd_window_match #(
  parameter int unsigned FIELD_W = 12
) (
  input  logic [FIELD_W-1:0] addr_hi,
  input  logic [FIELD_W-1:0] base_f,
  input  logic [FIELD_W-1:0] limit_f,
  output logic               hit
);
  // A base sits on a block start and a limit on a block end, so only the
  // upper address bits need to be compared. An inverted pair claims nothing.
  logic ge_base;
  logic le_limit;

  assign ge_base  = (addr_hi >= base_f);
  assign le_limit = (addr_hi <= limit_f);
  assign hit      = ge_base && le_limit;
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder #(
  parameter int unsigned ADDR_W  = mwd_pkg::ADDR_W_DEF,
  parameter int unsigned GRAN_W  = mwd_pkg::GRAN_W_DEF,
  parameter int unsigned REG_W   = mwd_pkg::REG_W_DEF,
  parameter int unsigned NUM_WIN = mwd_pkg::NUM_WIN_DEF,
  localparam int unsigned FIELD_W = ADDR_W - GRAN_W,
  localparam int unsigned SEL_W   = $clog2(NUM_WIN) + 1,
  localparam int unsigned BE_W    = REG_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [BE_W-1:0]   cfg_be,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit_valid,
  output logic              hit_np,
  output logic              hit_pf
);
  import mwd_pkg::*;

  logic [NUM_WIN*FIELD_W-1:0] base_flat;
  logic [NUM_WIN*FIELD_W-1:0] limit_flat;
  logic [NUM_WIN-1:0]         hit_comb;
  logic [NUM_WIN-1:0]         hit_q;
  logic                       vld_q;

  mwd_regfile #(
    .NUM_WIN(NUM_WIN),
    .REG_W  (REG_W),
    .FIELD_W(FIELD_W),
    .SEL_W  (SEL_W),
    .BE_W   (BE_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr_en),
    .rd_en     (cfg_rd_en),
    .sel       (cfg_sel),
    .be        (cfg_be),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .base_flat (base_flat),
    .limit_flat(limit_flat)
  );

  // One comparator per window, all evaluated in parallel.
  for (genvar w = 0; w < int'(NUM_WIN); w++) begin : g_cmp
    mwd_window_match #(.FIELD_W(FIELD_W)) u_match (
      .addr_hi(req_addr[ADDR_W-1:GRAN_W]),
      .base_f (base_flat[w*FIELD_W +: FIELD_W]),
      .limit_f(limit_flat[w*FIELD_W +: FIELD_W]),
      .hit    (hit_comb[w])
    );
  end

  // Registered result, qualified by the strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      hit_q <= '0;
    end else begin
      vld_q <= req_valid;
      hit_q <= req_valid ? hit_comb : '0;
    end
  end

  assign hit_valid = vld_q;
  assign hit_np    = hit_q[WIN_NP];
  assign hit_pf    = hit_q[WIN_PF];
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned LOW_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_rd_en,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             req_valid,
  input logic             hit_valid,
  input logic             hit_np,
  input logic             hit_pf
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!hit_valid && cfg_rdata == '0)); // R1
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst) cfg_rd_en |=> (cfg_rdata[LOW_W-1:0] == '0)); // R2
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst) !cfg_rd_en |=> $stable(cfg_rdata)); // R5
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) req_valid |=> hit_valid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !hit_valid); // R10
  AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (rst) !hit_valid |-> !(hit_np || hit_pf)); // R10
endmodule

bind mem_window_decoder mwd_checker #(
  .REG_W(REG_W),
  .LOW_W(REG_W - FIELD_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_rd_en(cfg_rd_en),
  .cfg_rdata(cfg_rdata),
  .req_valid(req_valid),
  .hit_valid(hit_valid),
  .hit_np   (hit_np),
  .hit_pf   (hit_pf)
);

// File: tb/mem_window_decoder_tb_top.sv
module mem_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [1:0]  cfg_be = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        hit_valid, hit_np, hit_pf;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // Bench copy of the register fields; index = cfg_sel.
  logic [11:0] shadow [4];
  logic [1:0]  exp_q [$];

  always #2.5 clk = ~clk;

  mem_window_decoder dut_i (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_sel(cfg_sel),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr),
    .hit_valid(hit_valid), .hit_np(hit_np), .hit_pf(hit_pf)
  );

  function automatic logic claims(input logic [31:0] a, input logic [11:0] b, input logic [11:0] l);
    logic [31:0] lo, hi;
    lo = {b, 20'h00000};
    hi = {l, 20'hFFFFF};
    return (a >= lo) && (a <= hi);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_rd_en = 1'b0; req_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    cfg_rd_en = 1'b0; req_valid = 1'b0;
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_be = be;
    if (be[1]) shadow[sel][11:4] = d[15:8];
    if (be[0]) shadow[sel][3:0]  = d[7:4];
  endtask

  task automatic cfg_read(input logic [1:0] sel, input string req);
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    cfg_rd_en = 1'b1; cfg_sel = sel;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    check(req, {16'h0, cfg_rdata}, {16'h0, shadow[sel], 4'h0});
  endtask

  // Driver: issue one request and push the expected hit pair.
  task automatic request(input logic [31:0] a);
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_rd_en = 1'b0;
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back({claims(a, shadow[2], shadow[3]), claims(a, shadow[0], shadow[1])});
  endtask

  // Monitor: compare each produced result with the oldest expected item.
  always @(negedge clk) begin
    if (!rst && hit_valid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected result", 32'h1, 32'h0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        check("R6/R7/R8/R9/R11 decode {pf,np}", {30'h0, hit_pf, hit_np}, {30'h0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 hit_valid after reset", {31'h0, hit_valid}, 32'h0);
    for (int i = 0; i < 4; i++) cfg_read(2'(i), "R1 reset register");
    // R12 only the first 1 MB covered after reset
    request(32'h0010_0000);
    request(32'hFFFF_FFFF);
    idle();

    // R2 bits 3:0 read as zero, writes ignored
    cfg_write(2'd0, 16'h123F, 2'b11);
    cfg_read(2'd0, "R2 low nibble dropped");
    check("R2 literal", {16'h0, cfg_rdata}, 32'h0000_1230);

    // R4 select mapping, non-prefetchable window 0x100..0x1FF
    cfg_write(2'd0, 16'h1000, 2'b11);
    cfg_write(2'd1, 16'h1FF0, 2'b11);
    cfg_write(2'd2, 16'h8000, 2'b11);
    cfg_write(2'd3, 16'h8FF0, 2'b11);
    for (int i = 0; i < 4; i++) cfg_read(2'(i), "R4 register select");

    // R6 R7 boundaries, back-to-back requests
    request(32'h0FFF_FFFF);
    request(32'h1000_0000);
    request(32'h1555_5555);
    request(32'h1FFF_FFFF);
    request(32'h2000_0000);
    // R9 independent windows
    request(32'h8000_0000);
    request(32'h8FFF_FFFF);
    request(32'h9000_0000);
    request(32'h7FFF_FFFF);
    idle();

    // R3 byte enables
    cfg_write(2'd3, 16'hAB00, 2'b10);
    cfg_read(2'd3, "R3 upper byte only");
    check("R3 literal upper", {16'h0, cfg_rdata}, 32'h0000_ABF0);
    cfg_write(2'd3, 16'h0050, 2'b01);
    cfg_read(2'd3, "R3 lower byte only");
    check("R3 literal lower", {16'h0, cfg_rdata}, 32'h0000_AB50);
    cfg_write(2'd3, 16'hFFFF, 2'b00);
    cfg_read(2'd3, "R3 no enables");
    cfg_write(2'd3, 16'h8FF0, 2'b11);

    // R11 R8 write then decode on the next cycle
    cfg_write(2'd1, 16'h0FF0, 2'b11);
    request(32'h1000_0000);   // inverted window, no hit
    cfg_write(2'd1, 16'h1FF0, 2'b11);
    request(32'h1000_0000);   // restored, hit
    // R8 single-block window
    cfg_write(2'd0, 16'h3000, 2'b11);
    cfg_write(2'd1, 16'h3000, 2'b11);
    request(32'h2FFF_FFFF);
    request(32'h3000_0000);
    request(32'h300F_FFFF);
    request(32'h3010_0000);
    // R7 top of address space
    cfg_write(2'd2, 16'hF000, 2'b11);
    cfg_write(2'd3, 16'hFFF0, 2'b11);
    request(32'hFFFF_FFFF);
    request(32'hEFFF_FFFF);
    idle();
    idle();

    check("R10 all results delivered", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule